// File: doc/BRIEF.md
# Two-Core Message Mailbox with Claim Locks

This block lets a sending core hand short messages to a receiving core. It holds four message slots. Each slot has a data word and a command word. Side A is the sender. It writes the data word first and then the command word. The command write raises that slot's pending flag. Side B is the receiver. It sees the pending flags in a status register and drops each flag by writing a one to its bit. Side B also owns a per-slot interrupt enable. The block drives one interrupt line per slot and one combined line toward side B.

A small bank of claim locks lets software on either core take ownership of the mailbox. Reading a free lock returns zero and takes the lock in the same access. Reading a taken lock returns one. Writing zero to a lock frees it. Both sides share one word-addressed map: slot data at 0x0 to 0x3, slot commands at 0x4 to 0x7, status at 0x8, interrupt enable at 0x9, and locks at 0xC to 0xF. Read data is registered and appears on the cycle after the read strobe.

Top module: `mbox_ipc`

## Requirements
- R1: After reset every data word, command word, pending flag and enable bit is zero, all locks are free, irq and irq_vec are low, and both read buses are zero.
- R2: A side A write to address i (0..3) stores the data word of slot i, and a write to address 4+i stores its command word. Either side reads the stored word back at the same address.
- R3: A side A write to the command address 4+i sets pending flag i. Flag i is bit i of the status register at address 0x8.
- R4: A side B write to address 0x8 clears each pending flag whose bit in the written word is one. A zero bit leaves its flag unchanged.
- R5: If side A writes command word i in the same cycle as side B clears flag i, the flag ends up set.
- R6: Bits 3:0 of address 0x9 are the per-slot interrupt enables, and only side B can write them. irq_vec[i] is high exactly when flag i and enable i are both one, and irq is the OR of irq_vec.
- R7: Side B writes to slot data or command addresses are ignored. Side A writes to the status and enable addresses are ignored.
- R8: A read of a free lock at 0xC+k returns 0 and marks lock k taken. Later reads return 1.
- R9: A write whose bit 0 is 0 to lock address 0xC+k frees lock k, from either side. A write with bit 0 set has no effect.
- R10: If both sides read the same free lock in one cycle, side A gets 0 and side B gets 1.
- R11: rd_en loads the read bus on the next clock edge, and the bus holds its value while rd_en is low. The unmapped addresses 0xA and 0xB read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_wr_en | input | 1 | Side A write strobe |
| a_rd_en | input | 1 | Side A read strobe |
| a_addr | input | 4 | Side A word address |
| a_wdata | input | DATA_W | Side A write data |
| a_rdata | output | DATA_W | Side A read data, registered |
| b_wr_en | input | 1 | Side B write strobe |
| b_rd_en | input | 1 | Side B read strobe |
| b_addr | input | 4 | Side B word address |
| b_wdata | input | DATA_W | Side B write data |
| b_rdata | output | DATA_W | Side B read data, registered |
| irq_vec | output | 4 | Per-slot interrupt toward side B |
| irq | output | 1 | OR of irq_vec |

## Verification
The bench passes a message through a slot and reads it back from the other side. This shows that the data and command words land in the right slot. The flag tests cover several cases that are easy to confuse: a set with the enable off and then on, a clear with a zero mask, a clear with a one mask, and a set and clear of the same slot in one cycle. These separate "set wins" from "clear wins" and show that masking gates only the line, never the flag. Writes aimed from the wrong side at each register group show which side owns each group. The lock tests follow one lock through claim, repeat read, a write of one, release and re-claim. A same-cycle read of a fresh lock by both sides checks the tie rule.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int ADDR_W = 4;
  localparam int N_ELEM = 4;
  localparam int N_LOCK = 4;
  localparam int IDX_W  = $clog2(N_ELEM);
  localparam int LK_W   = $clog2(N_LOCK);

  typedef enum logic [1:0] {
    RG_DATA = 2'd0,
    RG_CMD  = 2'd1,
    RG_CTRL = 2'd2,
    RG_LOCK = 2'd3
  } region_e;

  localparam logic [ADDR_W-1:0] ADDR_STAT = 4'h8;
  localparam logic [ADDR_W-1:0] ADDR_IEN  = 4'h9;
endpackage

// File: rtl/mbox_rst_sync.sv
module mbox_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_s_n <= meta_q;
    end
  end
endmodule

// File: rtl/mbox_elem_bank.sv
module mbox_elem_bank
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           a_wr_en,
  input  logic [ADDR_W-1:0]              a_addr,
  input  logic [DATA_W-1:0]              a_wdata,
  input  logic                           b_wr_en,
  input  logic [ADDR_W-1:0]              b_addr,
  input  logic [DATA_W-1:0]              b_wdata,
  output logic [N_ELEM-1:0][DATA_W-1:0]  data_q,
  output logic [N_ELEM-1:0][DATA_W-1:0]  cmd_q,
  output logic [N_ELEM-1:0]              flag_q,
  output logic [N_ELEM-1:0]              ien_q
);
  logic [N_ELEM-1:0] data_we, cmd_we;
  logic [N_ELEM-1:0] flag_d;
  logic              flag_en, ien_we;
  logic              clr_hit;

  always_comb begin
    clr_hit = b_wr_en && (b_addr == ADDR_STAT);
    ien_we  = b_wr_en && (b_addr == ADDR_IEN);
    for (int i = 0; i < N_ELEM; i++) begin
      data_we[i] = a_wr_en && (region_e'(a_addr[ADDR_W-1 -: 2]) == RG_DATA)
                   && (a_addr[IDX_W-1:0] == IDX_W'(i));
      cmd_we[i]  = a_wr_en && (region_e'(a_addr[ADDR_W-1 -: 2]) == RG_CMD)
                   && (a_addr[IDX_W-1:0] == IDX_W'(i));
      // a set in the same cycle overrides a clear
      flag_d[i]  = cmd_we[i] || (flag_q[i] && !(clr_hit && b_wdata[i]));
    end
    flag_en = clr_hit || (|cmd_we);
  end

  for (genvar i = 0; i < N_ELEM; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[i] <= '0;
        cmd_q[i]  <= '0;
      end else begin
        if (data_we[i]) data_q[i] <= a_wdata;
        if (cmd_we[i])  cmd_q[i]  <= a_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      ien_q  <= '0;
    end else begin
      if (flag_en) flag_q <= flag_d;
      if (ien_we)  ien_q  <= b_wdata[N_ELEM-1:0];
    end
  end
endmodule

// File: rtl/mbox_lock_bank.sv
module mbox_lock_bank
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_rd_en,
  input  logic              a_wr_en,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_wbit,
  input  logic              b_rd_en,
  input  logic              b_wr_en,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_wbit,
  output logic [N_LOCK-1:0] lock_q,
  output logic              a_lock_val,
  output logic              b_lock_val
);
  logic              a_in, b_in;
  logic [N_LOCK-1:0] lock_d;
  logic [N_LOCK-1:0] a_sel, b_sel;
  logic              lock_en;

  always_comb begin
    a_in = region_e'(a_addr[ADDR_W-1 -: 2]) == RG_LOCK;
    b_in = region_e'(b_addr[ADDR_W-1 -: 2]) == RG_LOCK;
    a_sel = '0;
    b_sel = '0;
    a_sel[a_addr[LK_W-1:0]] = a_in;
    b_sel[b_addr[LK_W-1:0]] = b_in;
    lock_en = (a_in && (a_rd_en || a_wr_en)) || (b_in && (b_rd_en || b_wr_en));
    for (int k = 0; k < N_LOCK; k++) begin
      if ((a_wr_en && a_sel[k] && !a_wbit) || (b_wr_en && b_sel[k] && !b_wbit))
        lock_d[k] = 1'b0;
      else
        lock_d[k] = lock_q[k] || (a_rd_en && a_sel[k]) || (b_rd_en && b_sel[k]);
    end
    a_lock_val = lock_q[a_addr[LK_W-1:0]];
    // side A wins a same-cycle claim of a free lock
    b_lock_val = lock_q[b_addr[LK_W-1:0]] || (a_rd_en && a_in && (a_sel == b_sel));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_q <= '0;
    else if (lock_en) lock_q <= lock_d;
  end
endmodule

// File: rtl/mbox_ipc.sv
module mbox_ipc
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_wr_en,
  input  logic              a_rd_en,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_wr_en,
  input  logic              b_rd_en,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic [N_ELEM-1:0] irq_vec,
  output logic              irq
);
  logic                          rst_s_n;
  logic [N_ELEM-1:0][DATA_W-1:0] data_q, cmd_q;
  logic [N_ELEM-1:0]             flag_q, ien_q;
  logic [N_LOCK-1:0]             lock_q;
  logic                          a_lock_val, b_lock_val;
  logic [DATA_W-1:0]             a_rd_d, b_rd_d;

  mbox_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n));

  mbox_elem_bank #(.DATA_W(DATA_W)) u_elem (
    .clk(clk), .rst_n(rst_s_n),
    .a_wr_en(a_wr_en), .a_addr(a_addr), .a_wdata(a_wdata),
    .b_wr_en(b_wr_en), .b_addr(b_addr), .b_wdata(b_wdata),
    .data_q(data_q), .cmd_q(cmd_q), .flag_q(flag_q), .ien_q(ien_q)
  );

  mbox_lock_bank u_lock (
    .clk(clk), .rst_n(rst_s_n),
    .a_rd_en(a_rd_en), .a_wr_en(a_wr_en), .a_addr(a_addr), .a_wbit(a_wdata[0]),
    .b_rd_en(b_rd_en), .b_wr_en(b_wr_en), .b_addr(b_addr), .b_wbit(b_wdata[0]),
    .lock_q(lock_q), .a_lock_val(a_lock_val), .b_lock_val(b_lock_val)
  );

  function automatic logic [DATA_W-1:0] rd_word(input logic [ADDR_W-1:0] ad,
                                                 input logic lk);
    logic [DATA_W-1:0] w;
    w = '0;
    unique case (region_e'(ad[ADDR_W-1 -: 2]))
      RG_DATA: w = data_q[ad[IDX_W-1:0]];
      RG_CMD:  w = cmd_q[ad[IDX_W-1:0]];
      RG_CTRL: begin
        if (ad == ADDR_STAT)     w[N_ELEM-1:0] = flag_q;
        else if (ad == ADDR_IEN) w[N_ELEM-1:0] = ien_q;
      end
      RG_LOCK: w[0] = lk;
      default: w = '0;
    endcase
    return w;
  endfunction

  always_comb begin
    a_rd_d = rd_word(a_addr, a_lock_val);
    b_rd_d = rd_word(b_addr, b_lock_val);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      if (a_rd_en) a_rdata <= a_rd_d;
      if (b_rd_en) b_rdata <= b_rd_d;
    end
  end

  assign irq_vec = flag_q & ien_q;
  assign irq     = |irq_vec;
endmodule

// File: rtl/mbox_ipc_chk.sv
module mbox_ipc_chk
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_s_n,
  input logic              a_wr_en,
  input logic              a_rd_en,
  input logic [ADDR_W-1:0] a_addr,
  input logic [DATA_W-1:0] a_rdata,
  input logic              b_wr_en,
  input logic              b_rd_en,
  input logic [ADDR_W-1:0] b_addr,
  input logic [DATA_W-1:0] b_wdata,
  input logic [DATA_W-1:0] b_rdata,
  input logic [N_ELEM-1:0] flag_q,
  input logic [N_LOCK-1:0] lock_q,
  input logic [N_ELEM-1:0] irq_vec
);
  for (genvar i = 0; i < N_ELEM; i++) begin : g_e
    // R3 and R5: a command write always leaves the flag set
    p_cmd_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
      (a_wr_en && a_addr == ADDR_W'(N_ELEM + i)) |=> flag_q[i]);
    p_w1c_clears_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
      (b_wr_en && b_addr == ADDR_STAT && b_wdata[i] &&
       !(a_wr_en && a_addr == ADDR_W'(N_ELEM + i))) |=> !flag_q[i]);
    p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
      $rose(irq_vec[i]) |-> ($past(a_wr_en && a_addr == ADDR_W'(N_ELEM + i)) ||
                             $past(b_wr_en && b_addr == ADDR_IEN && b_wdata[i])));
  end

  for (genvar k = 0; k < N_LOCK; k++) begin : g_l
    p_claim_free_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
      (a_rd_en && a_addr == ADDR_W'(12 + k) && !lock_q[k]) |=> (a_rdata == '0));
    p_hold_taken_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
      (lock_q[k] && !(a_wr_en && a_addr == ADDR_W'(12 + k)) &&
       !(b_wr_en && b_addr == ADDR_W'(12 + k))) |=> lock_q[k]);
    p_tie_b_loses_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
      (a_rd_en && b_rd_en && a_addr == ADDR_W'(12 + k) && b_addr == ADDR_W'(12 + k))
      |=> (b_rdata == DATA_W'(1)));
  end

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    !a_rd_en |=> $stable(a_rdata));
endmodule

bind mbox_ipc mbox_ipc_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_s_n(rst_s_n),
  .a_wr_en(a_wr_en), .a_rd_en(a_rd_en), .a_addr(a_addr), .a_rdata(a_rdata),
  .b_wr_en(b_wr_en), .b_rd_en(b_rd_en), .b_addr(b_addr), .b_wdata(b_wdata),
  .b_rdata(b_rdata), .flag_q(flag_q), .lock_q(lock_q), .irq_vec(irq_vec)
);

// File: tb/mbox_ipc_tb.sv
module mbox_ipc_tb;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          a_wr_en = 0, a_rd_en = 0, b_wr_en = 0, b_rd_en = 0;
  logic [3:0]    a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic [DW-1:0] a_rdata, b_rdata;
  logic [3:0]    irq_vec;
  logic          irq;

  int checks = 0;
  int errors = 0;

  logic [DW:0] q_exp[$];
  string       q_tag[$];

  always #5 clk = ~clk;

  mbox_ipc #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_wr_en(a_wr_en), .a_rd_en(a_rd_en), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_wr_en(b_wr_en), .b_rd_en(b_rd_en), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .irq_vec(irq_vec), .irq(irq)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares registered read data after each edge with queued expectations
  always @(negedge clk) begin
    while (q_exp.size() > 0) begin
      automatic logic [DW:0] e = q_exp.pop_front();
      automatic string t = q_tag.pop_front();
      check(t, e[DW] ? b_rdata : a_rdata, e[DW-1:0]);
    end
  end

  task automatic wr(input bit side_b, input logic [3:0] ad, input logic [DW-1:0] d);
    @(negedge clk);
    if (side_b) begin b_wr_en = 1; b_addr = ad; b_wdata = d; end
    else        begin a_wr_en = 1; a_addr = ad; a_wdata = d; end
    @(negedge clk);
    a_wr_en = 0; b_wr_en = 0;
  endtask

  task automatic rd(input bit side_b, input logic [3:0] ad, input logic [DW-1:0] exp,
                    input string tag);
    @(negedge clk);
    if (side_b) begin b_rd_en = 1; b_addr = ad; end
    else        begin a_rd_en = 1; a_addr = ad; end
    @(posedge clk);
    #1;
    a_rd_en = 0; b_rd_en = 0;
    q_exp.push_back({side_b, exp});
    q_tag.push_back(tag);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 irq_vec", {28'b0, irq_vec}, 0);
    check("R1 a_rdata", a_rdata, 0);
    rd(0, 4'h8, 0, "R1 status");
    rd(1, 4'h2, 0, "R1 data2");
    rd(0, 4'h9, 0, "R1 enables");

    // R2 message through slot 0 and slot 3
    wr(0, 4'h0, 32'h1234_5678);
    wr(0, 4'h3, 32'hA5A5_0F0F);
    rd(1, 4'h0, 32'h1234_5678, "R2 data0 via B");
    rd(0, 4'h3, 32'hA5A5_0F0F, "R2 data3 via A");

    // R3 command write sets flag; enable off keeps irq low (R6)
    wr(0, 4'h4, 32'hC0DE_0001);
    rd(1, 4'h4, 32'hC0DE_0001, "R2 cmd0");
    rd(1, 4'h8, 32'h1, "R3 status after cmd0");
    check("R6 irq masked", {31'b0, irq}, 0);

    // R6 enabling drives the line
    wr(1, 4'h9, 32'h1);
    check("R6 irq_vec", {28'b0, irq_vec}, 4'h1);
    check("R6 irq", {31'b0, irq}, 1);

    // R4 zero mask no effect, one mask clears
    wr(1, 4'h8, 32'h0);
    check("R4 zero mask keeps irq", {31'b0, irq}, 1);
    wr(1, 4'h8, 32'h1);
    check("R4 clear drops irq", {31'b0, irq}, 0);
    rd(0, 4'h8, 0, "R4 status cleared");

    // R5 same-cycle set and clear of slot 2
    @(negedge clk);
    a_wr_en = 1; a_addr = 4'h6; a_wdata = 32'h22;
    b_wr_en = 1; b_addr = 4'h8; b_wdata = 32'h4;
    @(negedge clk);
    a_wr_en = 0; b_wr_en = 0;
    rd(1, 4'h8, 32'h4, "R5 set wins");
    wr(1, 4'h9, 32'hF);
    check("R5 R6 irq_vec slot2", {28'b0, irq_vec}, 4'h4);
    wr(1, 4'h8, 32'hF);

    // R7 wrong-side writes ignored
    wr(1, 4'h1, 32'hFFFF_FFFF);
    rd(0, 4'h1, 0, "R7 B data write ignored");
    wr(1, 4'h5, 32'hFFFF_FFFF);
    rd(0, 4'h8, 0, "R7 B cmd write sets nothing");
    wr(0, 4'h9, 32'h0);
    rd(1, 4'h9, 32'hF, "R7 A enable write ignored");
    wr(0, 4'h8, 32'h0);
    wr(0, 4'h7, 32'h1);
    wr(0, 4'h8, 32'hF);
    rd(1, 4'h8, 32'h8, "R7 A clear ignored");

    // R11 unmapped reads and hold
    rd(0, 4'hA, 0, "R11 unmapped A");
    rd(1, 4'hB, 0, "R11 unmapped B");
    rd(0, 4'h0, 32'h1234_5678, "R11 load");
    @(negedge clk); @(negedge clk);
    check("R11 hold", a_rdata, 32'h1234_5678);

    // R8 claim
    rd(0, 4'hC, 0, "R8 first claim");
    rd(1, 4'hC, 1, "R8 taken seen by B");
    rd(0, 4'hC, 1, "R8 taken seen by A");
    // R9 write 1 no effect, write 0 frees
    wr(1, 4'hC, 32'h1);
    rd(1, 4'hC, 1, "R9 write one keeps");
    wr(0, 4'hC, 32'h0);
    rd(1, 4'hC, 0, "R9 release then reclaim by B");
    rd(0, 4'hC, 1, "R9 B holds");

    // R10 tie on a fresh lock
    @(negedge clk);
    a_rd_en = 1; a_addr = 4'hD;
    b_rd_en = 1; b_addr = 4'hD;
    @(posedge clk);
    #1;
    a_rd_en = 0; b_rd_en = 0;
    q_exp.push_back({1'b0, 32'h0}); q_tag.push_back("R10 A wins");
    q_exp.push_back({1'b1, 32'h1}); q_tag.push_back("R10 B loses");

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule